// File: doc/BRIEF.md
# Threshold Crossing Trigger Detector

This block watches a stream of signed ADC samples for one channel and raises a single-cycle trigger pulse when a programmed condition holds. The condition is picked by a 2-bit function code. Two codes are level tests: the sample lies below the limit, or above it. The other two codes are edge tests: the signal crosses the limit going up, or going down. Each edge test is gated by a hysteresis band that must be visited before the detector can fire again.

Each valid sample is evaluated in the cycle it arrives. The result leaves the block one clock later, together with a registered copy of the sample. The pulse therefore lines up with the sample that caused it. A two-channel system uses two instances.

Top module: `thresh_trig`

## Requirements
- R1: While reset is held and in the first cycle after it, `trig_o`, `smp_vld_o` and `smp_o` are zero. The crossing detector starts disarmed.
- R2: With function code 0, a valid sample that is strictly below `limit_i` in signed compare gives `trig_o` high on the next clock. A sample equal to the limit or above it gives no pulse.
- R3: With function code 1, a valid sample that is strictly above `limit_i` in signed compare gives `trig_o` high on the next clock. A sample equal to the limit gives no pulse.
- R4: With function code 2, a valid sample strictly below `limit_i - hyst_i` arms the detector. The first later valid sample strictly above `limit_i` gives one pulse and disarms it. Further samples above the limit give no pulse until the detector is armed again.
- R5: With function code 3, a valid sample strictly above `limit_i + hyst_i` arms the detector. The first later valid sample strictly below `limit_i` gives one pulse and disarms it.
- R6: A sample inside the hysteresis band does not arm the detector. An armed detector that sees samples at or on the arming side of the limit stays armed.
- R7: The band edges are computed at a width wide enough that no overflow occurs. `hyst_i` is unsigned, so a hysteresis of up to 2^32-1 on a limit at either end of the sample range never arms the detector.
- R8: A cycle in which `fn_i` or `limit_i` differs from its value in the previous cycle clears the armed state. That cycle can neither arm nor fire. A change of `hyst_i` alone keeps the armed state.
- R9: A cycle with `smp_vld_i` low gives no pulse and leaves the armed state unchanged.
- R10: `smp_o` and `smp_vld_o` are the `smp_i` and `smp_vld_i` of the previous cycle. `trig_o` is only high when `smp_vld_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_i | input | SAMPLE_W | Signed sample |
| smp_vld_i | input | 1 | Sample strobe |
| limit_i | input | SAMPLE_W | Signed threshold |
| hyst_i | input | HYST_W | Unsigned hysteresis width |
| fn_i | input | 2 | 0 below, 1 above, 2 rising crossing, 3 falling crossing |
| trig_o | output | 1 | Trigger pulse aligned to `smp_o` |
| smp_o | output | SAMPLE_W | Sample delayed one clock |
| smp_vld_o | output | 1 | Strobe delayed one clock |

## Verification
The only hidden state is the armed bit. A wrong value of it shows at the ports as a missing pulse or an extra pulse on the next valid sample past the limit, one clock after that sample. The bench drives arming, firing, clearing and invalid gaps in sequences that expose such an error at the first crossing that follows it. A reference model runs alongside and is compared on every clock. So a wrong band edge, a wrapped sum, or a missed clear on a limit change is reported within the same crossing.

// File: rtl/thr_trig_pkg.sv
package thr_trig_pkg;
   typedef enum logic [1:0] {
      FN_BELOW = 2'd0,
      FN_ABOVE = 2'd1,
      FN_RISE  = 2'd2,
      FN_FALL  = 2'd3
   } thr_fn_e;
endpackage

// File: rtl/thr_trig_cmp.sv
module thr_trig_cmp #(
   parameter int SAMPLE_W = 15,
   parameter int HYST_W   = 32
) (
   input  logic signed [SAMPLE_W-1:0] smp_i,
   input  logic signed [SAMPLE_W-1:0] lim_i,
   input  logic        [HYST_W-1:0]   hyst_i,
   output logic                       lt_o,
   output logic                       gt_o,
   output logic                       below_o,
   output logic                       above_o
);
   // two guard bits keep limit +/- hysteresis inside range
   localparam int EW = ((HYST_W > SAMPLE_W) ? HYST_W : SAMPLE_W) + 2;

   logic signed [EW-1:0] smp_x, lim_x, hyst_x, lo_x, hi_x;

   assign smp_x  = EW'(smp_i);
   assign lim_x  = EW'(lim_i);
   assign hyst_x = $signed({{(EW-HYST_W){1'b0}}, hyst_i});
   assign lo_x   = lim_x - hyst_x;
   assign hi_x   = lim_x + hyst_x;

   assign lt_o    = smp_i < lim_i;
   assign gt_o    = smp_i > lim_i;
   assign below_o = smp_x < lo_x;
   assign above_o = smp_x > hi_x;

   // R7: the band edges never fold back across the limit
   always_comb begin
      a_r7_band_order: assert (lo_x <= lim_x && hi_x >= lim_x);
   end
endmodule

// File: rtl/thr_trig_chg.sv
module thr_trig_chg #(
   parameter int SAMPLE_W = 15
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 fn_i,
   input  logic signed [SAMPLE_W-1:0] lim_i,
   output logic                       chg_o
);
   logic [1:0]                 fn_q;
   logic signed [SAMPLE_W-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fn_q  <= '0;
         lim_q <= '0;
      end else begin
         fn_q  <= fn_i;
         lim_q <= lim_i;
      end
   end

   assign chg_o = (fn_i != fn_q) || (lim_i != lim_q);
endmodule

// File: rtl/thr_trig_arm.sv
module thr_trig_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic set_i,
   input  logic fire_i,
   output logic armed_o
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                armed_q <= 1'b0;
      else if (clr_i || fire_i)  armed_q <= 1'b0;
      else if (set_i)            armed_q <= 1'b1;
   end

   assign armed_o = armed_q;

   // R4: a pulse needs a prior arm and consumes it
   a_r4_fire_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |-> armed_q);
   a_r4_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> !armed_q);
   // R8: a function or limit change leaves the detector disarmed
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !armed_q);
   // R9: an idle cycle keeps the armed state
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i && !fire_i) |=> (armed_q == $past(armed_q)));
endmodule

// File: rtl/thresh_trig.sv
module thresh_trig #(
   parameter int SAMPLE_W = 15,
   parameter int HYST_W   = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic signed [SAMPLE_W-1:0] smp_i,
   input  logic                       smp_vld_i,
   input  logic signed [SAMPLE_W-1:0] limit_i,
   input  logic        [HYST_W-1:0]   hyst_i,
   input  logic        [1:0]          fn_i,
   output logic                       trig_o,
   output logic signed [SAMPLE_W-1:0] smp_o,
   output logic                       smp_vld_o
);
   import thr_trig_pkg::*;

   generate
      if (SAMPLE_W < 2 || SAMPLE_W > 15) begin : g_bad_sw
         $error("thresh_trig: SAMPLE_W must be 2..15");
      end
      if (HYST_W < SAMPLE_W || HYST_W > 32) begin : g_bad_hw
         $error("thresh_trig: HYST_W must be SAMPLE_W..32");
      end
   endgenerate

   logic    lt, gt, below, above, chg, armed;
   logic    level, fire, set, fire_q, set_q, trig_d;
   thr_fn_e fn;

   assign fn = thr_fn_e'(fn_i);

   thr_trig_cmp #(.SAMPLE_W(SAMPLE_W), .HYST_W(HYST_W)) u_cmp (
      .smp_i(smp_i), .lim_i(limit_i), .hyst_i(hyst_i),
      .lt_o(lt), .gt_o(gt), .below_o(below), .above_o(above));

   thr_trig_chg #(.SAMPLE_W(SAMPLE_W)) u_chg (
      .clk(clk), .rst_n(rst_n), .fn_i(fn_i), .lim_i(limit_i), .chg_o(chg));

   always_comb begin
      level = 1'b0;
      fire  = 1'b0;
      set   = 1'b0;
      unique case (fn)
         FN_BELOW: level = lt;
         FN_ABOVE: level = gt;
         FN_RISE:  begin fire = armed & gt; set = below; end
         FN_FALL:  begin fire = armed & lt; set = above; end
         default:  level = 1'b0;
      endcase
   end

   assign fire_q = smp_vld_i & ~chg & fire;
   assign set_q  = smp_vld_i & ~chg & set;
   assign trig_d = smp_vld_i & (level | fire_q);

   thr_trig_arm u_arm (
      .clk(clk), .rst_n(rst_n), .clr_i(chg), .set_i(set_q),
      .fire_i(fire_q), .armed_o(armed));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_o    <= 1'b0;
         smp_o     <= '0;
         smp_vld_o <= 1'b0;
      end else begin
         trig_o    <= trig_d;
         smp_o     <= smp_i;
         smp_vld_o <= smp_vld_i;
      end
   end

   // R2: below-limit level test
   a_r2_below: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld_i && fn_i == 2'd0 && smp_i < limit_i) |=> trig_o);
   // R3: above-limit level test
   a_r3_above: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld_i && fn_i == 2'd1 && smp_i > limit_i) |=> trig_o);
   // R9: no strobe, no pulse
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld_i |=> !trig_o);
   // R10: a pulse always sits on a valid output sample
   a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> smp_vld_o);
endmodule

// File: tb/thresh_trig_tb.sv
`timescale 1ns/1ps
module thresh_trig_tb;
   localparam int SW = 15;
   localparam int HW = 32;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic signed [SW-1:0] smp = '0;
   logic                 vld = 1'b0;
   logic signed [SW-1:0] lim = '0;
   logic [HW-1:0]        hyst = '0;
   logic [1:0]           fn = 2'd0;
   logic                 trig_o, smp_vld_o;
   logic signed [SW-1:0] smp_o;

   int    n_run = 0, n_fail = 0;
   string tag = "R1";

   // reference model state
   bit     m_armed = 0;
   int     m_pfn = 0;
   longint m_plim = 0;
   bit     e_trig = 0, e_vld = 0;
   longint e_smp = 0;

   always #4 clk = ~clk;

   thresh_trig #(.SAMPLE_W(SW), .HYST_W(HW)) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_i(smp), .smp_vld_i(vld),
      .limit_i(lim), .hyst_i(hyst), .fn_i(fn),
      .trig_o(trig_o), .smp_o(smp_o), .smp_vld_o(smp_vld_o));

   always @(posedge clk) begin
      longint s, l, h;
      bit chg;
      s = longint'(smp);
      l = longint'(lim);
      h = longint'(hyst);
      if (!rst_n) begin
         m_armed = 0; m_pfn = 0; m_plim = 0;
         e_trig = 0; e_vld = 0; e_smp = 0;
      end else begin
         chg = (int'(fn) != m_pfn) || (l != m_plim);
         e_trig = 0;
         if (chg) m_armed = 0;
         if (vld) begin
            case (fn)
               2'd0: e_trig = (s < l);
               2'd1: e_trig = (s > l);
               2'd2: if (!chg) begin
                  if (m_armed && s > l) begin e_trig = 1; m_armed = 0; end
                  else if (s < l - h) m_armed = 1;
               end
               default: if (!chg) begin
                  if (m_armed && s < l) begin e_trig = 1; m_armed = 0; end
                  else if (s > l + h) m_armed = 1;
               end
            endcase
         end
         e_vld = vld;
         e_smp = s;
         m_pfn = int'(fn);
         m_plim = l;
      end
   end

   always @(negedge clk) begin
      n_run++;
      if (trig_o !== e_trig) begin
         n_fail++;
         $display("FAIL %s trig_o actual %0b expected %0b at %0t", tag, trig_o, e_trig, $time);
      end
      n_run++;
      if (smp_vld_o !== e_vld || longint'(smp_o) != e_smp) begin
         n_fail++;
         $display("FAIL R10 vld/smp actual %0b/%0d expected %0b/%0d", smp_vld_o, smp_o, e_vld, e_smp);
      end
   end

   task automatic put(input bit v, input int s);
      @(negedge clk);
      vld = v;
      smp = SW'(s);
   endtask

   task automatic cfg(input int f, input int l, input longint h);
      @(negedge clk);
      vld = 1'b0;
      fn = 2'(f);
      lim = SW'(l);
      hyst = HW'(h);
   endtask

   initial begin
      #100000000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      tag = "R1";
      repeat (3) @(negedge clk);
      n_run++;
      if (trig_o !== 1'b0 || smp_vld_o !== 1'b0 || smp_o !== '0) begin
         n_fail++;
         $display("FAIL R1 reset outputs actual %0b/%0b/%0d expected 0/0/0", trig_o, smp_vld_o, smp_o);
      end
      rst_n = 1'b1;
      // R1: detector starts disarmed, so a rise without a prior arm is silent
      cfg(2, 0, 10);
      put(1, 500);
      put(0, 0);

      tag = "R2";
      cfg(0, 100, 0);
      for (int s = -200; s <= 200; s += 37) put(1, s);
      put(1, 100); put(1, 99); put(1, 101);
      cfg(0, -50, 0);
      put(1, -51); put(1, -50); put(1, -16384); put(1, 16383);

      tag = "R3";
      cfg(1, 100, 0);
      for (int s = -200; s <= 200; s += 37) put(1, s);
      put(1, 100); put(1, 101); put(1, 99);
      cfg(1, -50, 0);
      put(1, -49); put(1, -50); put(1, -16384);

      tag = "R4";
      cfg(2, 0, 50);
      put(1, 10); put(1, 60); put(1, -60); put(1, -10); put(1, 0);
      put(1, 5); put(1, 20); put(1, 30); put(1, -51); put(1, 100);

      tag = "R5";
      cfg(3, 0, 50);
      put(1, -10); put(1, -60); put(1, 60); put(1, 10); put(1, 0);
      put(1, -5); put(1, -20); put(1, 51); put(1, -100);

      tag = "R6";
      cfg(2, 0, 50);
      put(1, -50); put(1, -1); put(1, 5);
      put(1, -51); put(1, -30); put(1, 0); put(1, -5); put(1, 7);

      tag = "R9";
      cfg(2, 0, 20);
      put(1, -30); put(0, 100); put(0, 200); put(0, -100);
      put(1, 3); put(0, 50); put(1, 50);

      tag = "R8";
      cfg(2, 0, 20);
      put(1, -30);
      @(negedge clk); lim = SW'(1); smp = SW'(10); vld = 1'b1;
      put(1, 10);
      put(1, -30);
      @(negedge clk); hyst = 32'd5; smp = SW'(10);
      put(1, -30);
      @(negedge clk); fn = 2'd3; smp = SW'(-40);
      @(negedge clk); fn = 2'd2; smp = SW'(-40);
      put(1, 10);
      @(negedge clk); lim = SW'(-100); smp = SW'(-40); vld = 1'b1;
      put(1, 0);

      tag = "R7";
      cfg(2, -16384, 64'hFFFF_FFFF);
      put(1, -16384); put(1, 16383); put(1, -16384); put(1, 16383);
      cfg(3, 16383, 64'hFFFF_FFFF);
      put(1, 16383); put(1, -16384); put(1, 16383); put(1, -16384);
      cfg(2, 16383, 64'hFFFF_FFFF);
      put(1, -16384); put(1, 16383);

      tag = "R10";
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if ($urandom_range(0, 15) == 0) fn = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 31) == 0) lim = SW'(int'($urandom_range(0, 400)) - 200);
         if ($urandom_range(0, 31) == 0) hyst = HW'($urandom_range(0, 100));
         vld = ($urandom_range(0, 3) != 0);
         smp = SW'(int'($urandom_range(0, 800)) - 400);
      end

      put(0, 0);
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule